// File: doc/BRIEF.md
# Branch Target Bundle Cache

This block sits beside the fetch unit and remembers, for branches that were taken before, the opening instructions of where they went. Fetch presents a branch's address on the lookup port. On the next cycle the block reports a hit flag, a bundle of up to four target-stream instructions and how many of them are usable. On a hit, fetch can queue the target instructions one cycle earlier than an instruction-cache read would allow. The usable count is below four when the target stream runs into a block boundary.

Storage is 32 sets of 4 ways, 128 entries in all. The set comes from the low word-address bits of the branch address and the rest of the address is the tag. When a taken branch resolves, the update port writes its bundle. If the branch already has an entry, that entry is overwritten. Otherwise the bundle goes to the lowest empty way of the set, or, when the set is full, to the way a per-set tree pseudo-LRU points at. A single flush input drops every entry at once, for example after code is modified.

Top module: `tgt_bundle_cache`

## Requirements
- R1: A synchronous reset empties the cache and clears the lookup outputs; every lookup that follows reset misses until an update is written.
- R2: Lookup outputs are registered. They reflect the request accepted one clock earlier, and when `lk_valid` was low in that cycle they show a miss.
- R3: A lookup hits when a valid way of set `addr[6:2]` holds tag `addr[31:7]`. It then returns that entry's bundle (instruction slot k in bits 32k+31:32k) and its stored count of usable slots, 1 to 4.
- R4: On a miss, `lk_hit`, `lk_count` and `lk_insns` are all zero.
- R5: An update whose tag already sits in a valid way of its set rewrites that way. No second copy is made, and the other ways of the set are kept.
- R6: An update with no tag match fills the lowest-numbered empty way of the set. If the set is full, it replaces the way chosen by the pseudo-LRU tree.
- R7: Each set keeps three tree bits: a root and one bit per half. A bit of 0 points the victim search to the lower-numbered half. A lookup hit and a fill both set the bits on the accessed way's path to point away from it. When both touch one set in the same cycle, the hit is applied first and the fill second, and the fill's victim comes from the state before that cycle.
- R8: Each set holds up to four distinct tags at once. Sets are independent, and filling one set never disturbs another.
- R9: A pulse on `inv_all` clears every entry at that clock edge. A lookup in the next cycle misses.
- R10: An update presented in the same cycle as `inv_all` is discarded.
- R11: A lookup and an update in the same cycle are handled as read-before-write: the lookup sees the contents from before that update.
- R12: A lookup in the same cycle as `inv_all` reports the contents from before the flush.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lk_valid | input | 1 | Lookup request this cycle |
| lk_addr | input | 32 | Branch instruction byte address to look up |
| lk_hit | output | 1 | Registered hit flag for the previous lookup |
| lk_insns | output | 128 | Registered target bundle, four 32-bit slots |
| lk_count | output | 3 | Registered number of usable slots (0 on miss) |
| up_valid | input | 1 | Write a resolved taken branch's bundle |
| up_addr | input | 32 | Branch instruction byte address to write |
| up_insns | input | 128 | Target bundle to store |
| up_count | input | 3 | Usable slots in the bundle, 1 to 4 |
| inv_all | input | 1 | Flush every entry |

## Verification
A lookup can fall in the same cycle as an update or a flush, and the hit and the fill can then touch the same set's replacement bits. Directed steps put a lookup beside an update of the same address, put a lookup of a present entry beside `inv_all`, and put an update beside `inv_all`. The cycle after each is judged as read-before-write or as discarded. The random phase confines traffic to four sets and six tags so that these collisions, and same-set hit-plus-fill cycles, recur often. A bench-side model that applies the hit before the fill predicts every later victim.

// File: rtl/tbc_pkg.sv
package tbc_pkg;

  localparam int unsigned TREE_MAX = 64;
  typedef logic [TREE_MAX-1:0] tree_t;
  typedef int unsigned uint_t;

  // Walk the tree from the root; a 0 bit sends the search to the lower half.
  function automatic uint_t tree_victim(tree_t t, uint_t levels);
    uint_t node;
    uint_t way;
    uint_t b;
    node = 0;
    way  = 0;
    for (uint_t l = 0; l < levels; l++) begin
      b    = t[node] ? 1 : 0;
      way  = (way << 1) | b;
      node = 2 * node + 1 + b;
    end
    return way;
  endfunction

  // Point every node on the accessed way's path away from it.
  function automatic tree_t tree_touch(tree_t t, uint_t way, uint_t levels);
    tree_t r;
    uint_t node;
    uint_t b;
    r    = t;
    node = 0;
    for (uint_t l = 0; l < levels; l++) begin
      b       = (way >> (levels - 1 - l)) & 1;
      r[node] = (b == 0);
      node    = 2 * node + 1 + b;
    end
    return r;
  endfunction

endpackage

// File: rtl/tbc_way.sv
module tbc_way #(
  parameter int unsigned SETS   = 32,
  parameter int unsigned IDX_W  = 5,
  parameter int unsigned TAG_W  = 25,
  parameter int unsigned DATA_W = 128,
  parameter int unsigned CNT_W  = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              inv_all,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [TAG_W-1:0]  wr_tag,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [CNT_W-1:0]  wr_cnt,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic              rd_vld,
  output logic [TAG_W-1:0]  rd_tag,
  output logic [DATA_W-1:0] rd_data,
  output logic [CNT_W-1:0]  rd_cnt,
  input  logic [IDX_W-1:0]  pr_idx,
  output logic              pr_vld,
  output logic [TAG_W-1:0]  pr_tag
);

  logic [SETS-1:0]   vld_q;
  logic [TAG_W-1:0]  tag_mem  [SETS];
  logic [DATA_W-1:0] data_mem [SETS];
  logic [CNT_W-1:0]  cnt_mem  [SETS];

  // Valid bits live in flops so that a flush takes one edge.
  always_ff @(posedge clk) begin
    if (rst || inv_all) begin
      vld_q <= '0;
    end else if (wr_en) begin
      vld_q[wr_idx] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) begin
      tag_mem[wr_idx]  <= wr_tag;
      data_mem[wr_idx] <= wr_data;
      cnt_mem[wr_idx]  <= wr_cnt;
    end
  end

  assign rd_vld  = vld_q[rd_idx];
  assign rd_tag  = tag_mem[rd_idx];
  assign rd_data = data_mem[rd_idx];
  assign rd_cnt  = cnt_mem[rd_idx];
  assign pr_vld  = vld_q[pr_idx];
  assign pr_tag  = tag_mem[pr_idx];

endmodule

// File: rtl/tbc_plru.sv
module tbc_plru
  import tbc_pkg::*;
#(
  parameter int unsigned SETS  = 32,
  parameter int unsigned WAYS  = 4,
  parameter int unsigned IDX_W = 5,
  parameter int unsigned WAY_W = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             hit_en,
  input  logic [IDX_W-1:0] hit_idx,
  input  logic [WAY_W-1:0] hit_way,
  input  logic             fill_en,
  input  logic [IDX_W-1:0] fill_idx,
  input  logic [WAY_W-1:0] fill_way,
  input  logic [IDX_W-1:0] q_idx,
  output logic [WAY_W-1:0] q_victim
);

  localparam int unsigned TREE_W = (WAYS > 1) ? WAYS - 1 : 1;
  localparam int unsigned LEVELS = $clog2(WAYS);

  logic [TREE_W-1:0] st_q [SETS];
  tree_t cur_h, nxt_h, cur_f, nxt_f, cur_q;

  always_comb begin
    cur_h = '0;
    cur_h[TREE_W-1:0] = st_q[hit_idx];
    nxt_h = tree_touch(cur_h, uint_t'(hit_way), LEVELS);
    cur_f = '0;
    // Same-set hit and fill: the fill builds on the already-touched state.
    cur_f[TREE_W-1:0] = (hit_en && hit_idx == fill_idx) ? nxt_h[TREE_W-1:0]
                                                        : st_q[fill_idx];
    nxt_f = tree_touch(cur_f, uint_t'(fill_way), LEVELS);
    cur_q = '0;
    cur_q[TREE_W-1:0] = st_q[q_idx];
    q_victim = WAY_W'(tree_victim(cur_q, LEVELS));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < SETS; s++) st_q[s] <= '0;
    end else begin
      if (hit_en)  st_q[hit_idx]  <= nxt_h[TREE_W-1:0];
      if (fill_en) st_q[fill_idx] <= nxt_f[TREE_W-1:0];
    end
  end

endmodule

// File: rtl/tgt_bundle_cache.sv
module tgt_bundle_cache #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned INSN_W = 32,
  parameter int unsigned SLOTS  = 4,
  parameter int unsigned SETS   = 32,
  parameter int unsigned WAYS   = 4,
  parameter int unsigned OFS_W  = 2
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    lk_valid,
  input  logic [ADDR_W-1:0]       lk_addr,
  output logic                    lk_hit,
  output logic [SLOTS*INSN_W-1:0] lk_insns,
  output logic [$clog2(SLOTS+1)-1:0] lk_count,
  input  logic                    up_valid,
  input  logic [ADDR_W-1:0]       up_addr,
  input  logic [SLOTS*INSN_W-1:0] up_insns,
  input  logic [$clog2(SLOTS+1)-1:0] up_count,
  input  logic                    inv_all
);

  localparam int unsigned IDX_W  = $clog2(SETS);
  localparam int unsigned WAY_W  = (WAYS > 1) ? $clog2(WAYS) : 1;
  localparam int unsigned CNT_W  = $clog2(SLOTS + 1);
  localparam int unsigned DATA_W = SLOTS * INSN_W;
  localparam int unsigned TAG_W  = ADDR_W - OFS_W - IDX_W;

  logic [IDX_W-1:0] lk_idx, up_idx;
  logic [TAG_W-1:0] lk_tag, up_tag;

  assign lk_idx = lk_addr[OFS_W +: IDX_W];
  assign lk_tag = lk_addr[ADDR_W-1 -: TAG_W];
  assign up_idx = up_addr[OFS_W +: IDX_W];
  assign up_tag = up_addr[ADDR_W-1 -: TAG_W];

  logic [WAYS-1:0]   rd_vld, pr_vld, wr_sel, lk_match, up_match;
  logic [TAG_W-1:0]  rd_tag  [WAYS];
  logic [TAG_W-1:0]  pr_tag  [WAYS];
  logic [DATA_W-1:0] rd_data [WAYS];
  logic [CNT_W-1:0]  rd_cnt  [WAYS];

  logic             fill_en, hit_en, hit_any, upm_any, free_any;
  logic [WAY_W-1:0] hit_way, upm_way, free_way, plru_way, fill_way;
  logic [DATA_W-1:0] sel_data;
  logic [CNT_W-1:0]  sel_cnt;

  assign fill_en = up_valid && !inv_all;

  for (genvar g = 0; g < WAYS; g++) begin : g_way
    assign lk_match[g] = rd_vld[g] && (rd_tag[g] == lk_tag);
    assign up_match[g] = pr_vld[g] && (pr_tag[g] == up_tag);
    assign wr_sel[g]   = fill_en && (fill_way == WAY_W'(g));

    tbc_way #(
      .SETS(SETS), .IDX_W(IDX_W), .TAG_W(TAG_W), .DATA_W(DATA_W), .CNT_W(CNT_W)
    ) u_way (
      .clk(clk), .rst(rst), .inv_all(inv_all),
      .wr_en(wr_sel[g]), .wr_idx(up_idx), .wr_tag(up_tag),
      .wr_data(up_insns), .wr_cnt(up_count),
      .rd_idx(lk_idx), .rd_vld(rd_vld[g]), .rd_tag(rd_tag[g]),
      .rd_data(rd_data[g]), .rd_cnt(rd_cnt[g]),
      .pr_idx(up_idx), .pr_vld(pr_vld[g]), .pr_tag(pr_tag[g])
    );
  end

  // Way selection: highest index scanned first so the lowest match wins.
  always_comb begin
    hit_any  = 1'b0;
    hit_way  = '0;
    upm_any  = 1'b0;
    upm_way  = '0;
    free_any = 1'b0;
    free_way = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (lk_match[w]) begin hit_any  = 1'b1; hit_way  = WAY_W'(w); end
      if (up_match[w]) begin upm_any  = 1'b1; upm_way  = WAY_W'(w); end
      if (!pr_vld[w])  begin free_any = 1'b1; free_way = WAY_W'(w); end
    end
    sel_data = rd_data[hit_way];
    sel_cnt  = rd_cnt[hit_way];
    if (upm_any)       fill_way = upm_way;
    else if (free_any) fill_way = free_way;
    else               fill_way = plru_way;
  end

  assign hit_en = lk_valid && hit_any;

  tbc_plru #(
    .SETS(SETS), .WAYS(WAYS), .IDX_W(IDX_W), .WAY_W(WAY_W)
  ) u_plru (
    .clk(clk), .rst(rst),
    .hit_en(hit_en), .hit_idx(lk_idx), .hit_way(hit_way),
    .fill_en(fill_en), .fill_idx(up_idx), .fill_way(fill_way),
    .q_idx(up_idx), .q_victim(plru_way)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      lk_hit   <= 1'b0;
      lk_insns <= '0;
      lk_count <= '0;
    end else begin
      lk_hit   <= hit_en;
      lk_insns <= hit_en ? sel_data : '0;
      lk_count <= hit_en ? sel_cnt  : '0;
    end
  end

endmodule

// File: rtl/tbc_checker.sv
module tbc_checker #(
  parameter int unsigned SLOTS  = 4,
  parameter int unsigned INSN_W = 32
) (
  input logic                       clk,
  input logic                       rst,
  input logic                       lk_valid,
  input logic                       lk_hit,
  input logic [SLOTS*INSN_W-1:0]    lk_insns,
  input logic [$clog2(SLOTS+1)-1:0] lk_count,
  input logic                       inv_all
);

  localparam int unsigned CNT_W = $clog2(SLOTS + 1);

  p_reset_clears_r1: assert property (@(posedge clk)
    rst |=> (!lk_hit && lk_count == '0 && lk_insns == '0));

  p_idle_no_hit_r2: assert property (@(posedge clk) disable iff (rst)
    !lk_valid |=> !lk_hit);

  p_count_range_r3: assert property (@(posedge clk) disable iff (rst)
    lk_hit |-> (lk_count != '0 && lk_count <= CNT_W'(SLOTS)));

  p_miss_zero_r4: assert property (@(posedge clk) disable iff (rst)
    !lk_hit |-> (lk_count == '0 && lk_insns == '0));

  p_flush_misses_r9: assert property (@(posedge clk) disable iff (rst)
    ($past(inv_all) && lk_valid) |=> !lk_hit);

endmodule

bind tgt_bundle_cache tbc_checker #(.SLOTS(SLOTS), .INSN_W(INSN_W)) u_chk (
  .clk(clk), .rst(rst), .lk_valid(lk_valid), .lk_hit(lk_hit),
  .lk_insns(lk_insns), .lk_count(lk_count), .inv_all(inv_all)
);

// File: tb/tb_tgt_bundle_cache.sv
`timescale 1ns/1ps
module tb_tgt_bundle_cache;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         lk_valid = 1'b0;
  logic [31:0]  lk_addr = '0;
  logic         lk_hit;
  logic [127:0] lk_insns;
  logic [2:0]   lk_count;
  logic         up_valid = 1'b0;
  logic [31:0]  up_addr = '0;
  logic [127:0] up_insns = '0;
  logic [2:0]   up_count = '0;
  logic         inv_all = 1'b0;

  int n_chk = 0;
  int n_fail = 0;

  always #4 clk = ~clk;

  tgt_bundle_cache dut (
    .clk(clk), .rst(rst), .lk_valid(lk_valid), .lk_addr(lk_addr),
    .lk_hit(lk_hit), .lk_insns(lk_insns), .lk_count(lk_count),
    .up_valid(up_valid), .up_addr(up_addr), .up_insns(up_insns),
    .up_count(up_count), .inv_all(inv_all)
  );

  // Reference state built from the requirements.
  bit          mv [32][4];
  logic [24:0] mt [32][4];
  logic [127:0] md [32][4];
  logic [2:0]  mc [32][4];
  logic [2:0]  mtree [32];   // bit0 root, bit1 lower half, bit2 upper half

  function automatic int pick(logic [2:0] t);
    if (!t[0]) return t[1] ? 1 : 0;
    return t[2] ? 3 : 2;
  endfunction

  function automatic logic [2:0] touch(logic [2:0] t, int w);
    logic [2:0] r = t;
    if (w < 2) begin r[0] = 1'b1; r[1] = (w == 0); end
    else       begin r[0] = 1'b0; r[2] = (w == 2); end
    return r;
  endfunction

  function automatic logic [31:0] mk(logic [24:0] tag, logic [4:0] idx);
    return {tag, idx, 2'b00};
  endfunction

  function automatic logic [127:0] bnd(logic [31:0] n);
    return {n + 32'd3, n + 32'd2, n + 32'd1, n};
  endfunction

  task automatic chk(input string r, input string f, input logic [127:0] act, input logic [127:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", r, f, act, exp);
    end
  endtask

  task automatic step(input string req, input bit lv, input logic [31:0] la,
                      input bit uv, input logic [31:0] ua, input logic [127:0] ud,
                      input logic [2:0] uc, input bit inv);
    logic [4:0] li, ui;
    logic [24:0] lt, ut;
    bit eh;
    logic [127:0] ed;
    logic [2:0] ec;
    int hw, fw;
    string r;
    lk_valid = lv; lk_addr = la; up_valid = uv; up_addr = ua;
    up_insns = ud; up_count = uc; inv_all = inv;
    li = la[6:2]; lt = la[31:7]; ui = ua[6:2]; ut = ua[31:7];
    eh = 1'b0; ed = '0; ec = '0; hw = 0; fw = -1;
    if (lv)
      for (int w = 0; w < 4; w++)
        if (mv[li][w] && mt[li][w] == lt) begin
          eh = 1'b1; hw = w; ed = md[li][w]; ec = mc[li][w];
        end
    if (uv && !inv) begin
      for (int w = 0; w < 4; w++) if (mv[ui][w] && mt[ui][w] == ut) fw = w;
      if (fw < 0) for (int w = 3; w >= 0; w--) if (!mv[ui][w]) fw = w;
      if (fw < 0) fw = pick(mtree[ui]);
    end
    if (eh) mtree[li] = touch(mtree[li], hw);
    if (fw >= 0) begin
      mtree[ui] = touch(mtree[ui], fw);
      mv[ui][fw] = 1'b1; mt[ui][fw] = ut; md[ui][fw] = ud; mc[ui][fw] = uc;
    end
    if (inv) for (int s = 0; s < 32; s++) for (int w = 0; w < 4; w++) mv[s][w] = 1'b0;
    @(posedge clk);
    @(negedge clk);
    r = (req == "RND") ? (eh ? "R3" : "R4") : req;
    chk(r, "hit", {127'd0, lk_hit}, {127'd0, eh});
    chk(r, "count", {125'd0, lk_count}, {125'd0, ec});
    chk(r, "insns", lk_insns, ed);
    lk_valid = 1'b0; up_valid = 1'b0; inv_all = 1'b0;
  endtask

  task automatic look(input string req, input logic [31:0] a);
    step(req, 1'b1, a, 1'b0, '0, '0, 3'd0, 1'b0);
  endtask

  task automatic fill(input logic [31:0] a, input logic [127:0] d, input logic [2:0] c);
    step("R4", 1'b0, '0, 1'b1, a, d, c, 1'b0);
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #1200000;
    n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [24:0] tags [6];
    for (int s = 0; s < 32; s++) begin
      mtree[s] = '0;
      for (int w = 0; w < 4; w++) mv[s][w] = 1'b0;
    end
    tags = '{25'h0000011, 25'h0000a22, 25'h1abc033, 25'h0ff0044, 25'h1234555, 25'h0000066};
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R1: outputs cleared, first lookups miss
    chk("R1", "hit", {127'd0, lk_hit}, 128'd0);
    chk("R1", "count", {125'd0, lk_count}, 128'd0);
    look("R1", mk(25'h11, 5'd3));
    look("R1", mk(25'h0, 5'd0));

    // R3: hit returns bundle and count; R2: idle cycle shows miss
    fill(mk(25'h11, 5'd3), bnd(32'h100), 3'd3);
    look("R3", mk(25'h11, 5'd3));
    step("R2", 1'b0, mk(25'h11, 5'd3), 1'b0, '0, '0, 3'd0, 1'b0);
    look("R4", mk(25'h12, 5'd3));

    // R11: lookup and update of the same address in one cycle
    step("R11", 1'b1, mk(25'h77, 5'd4), 1'b1, mk(25'h77, 5'd4), bnd(32'h200), 3'd4, 1'b0);
    look("R11", mk(25'h77, 5'd4));

    // R5: rewrite on tag match, then three more tags all coexist
    fill(mk(25'h11, 5'd3), bnd(32'h300), 3'd2);
    fill(mk(25'h21, 5'd3), bnd(32'h310), 3'd4);
    fill(mk(25'h31, 5'd3), bnd(32'h320), 3'd1);
    fill(mk(25'h41, 5'd3), bnd(32'h330), 3'd4);
    look("R5", mk(25'h11, 5'd3));
    look("R5", mk(25'h21, 5'd3));
    look("R5", mk(25'h31, 5'd3));
    look("R5", mk(25'h41, 5'd3));
    look("R8", mk(25'h77, 5'd4));

    // R6/R7: set 9, four fills, touch the first, fifth tag evicts the third
    fill(mk(25'hA, 5'd9), bnd(32'h400), 3'd4);
    fill(mk(25'hB, 5'd9), bnd(32'h410), 3'd4);
    fill(mk(25'hC, 5'd9), bnd(32'h420), 3'd4);
    fill(mk(25'hD, 5'd9), bnd(32'h430), 3'd4);
    look("R7", mk(25'hA, 5'd9));
    fill(mk(25'hE, 5'd9), bnd(32'h440), 3'd2);
    look("R6", mk(25'hC, 5'd9));
    look("R6", mk(25'hB, 5'd9));
    look("R8", mk(25'hA, 5'd9));
    look("R8", mk(25'hD, 5'd9));
    look("R7", mk(25'hE, 5'd9));

    // R12: lookup beside flush sees old contents; R9: next lookup misses
    step("R12", 1'b1, mk(25'hA, 5'd9), 1'b0, '0, '0, 3'd0, 1'b1);
    look("R9", mk(25'hA, 5'd9));
    look("R9", mk(25'h21, 5'd3));
    // R10: update beside flush is dropped
    step("R10", 1'b0, '0, 1'b1, mk(25'h5, 5'd1), bnd(32'h500), 3'd4, 1'b1);
    look("R10", mk(25'h5, 5'd1));

    // Random phase on four sets and six tags
    void'($urandom(32'd2024));
    for (int i = 0; i < 3000; i++) begin
      logic [31:0] la, ua;
      bit lv, uv, inv;
      la  = mk(tags[$urandom_range(5)], 5'($urandom_range(3)));
      ua  = mk(tags[$urandom_range(5)], 5'($urandom_range(3)));
      lv  = ($urandom_range(99) < 70);
      uv  = ($urandom_range(99) < 40);
      inv = ($urandom_range(199) == 0);
      step("RND", lv, la, uv, ua, {$urandom, $urandom, $urandom, $urandom},
           3'($urandom_range(3) + 1), inv);
    end
    finish_run();
  end

endmodule